// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. Out of reset it waits out a long start-up pause, then runs eight warm-up refresh cycles before it declares the memory ready. After that, an interval timer produces one refresh demand per row period, so that every row is covered inside the retention window. Demands that cannot be served at once are held in a small saturating backlog. When the access controller grants the bus, the whole backlog is issued back to back.

Each burst uses one of two refresh styles, chosen by a mode input that is sampled at the grant. In CAS-before-RAS style the memory's own row counter picks the row and the row output is left alone. Column strobe falls a set number of cycles before row strobe and stays low while row strobe is low. Inside a burst it also stays low across the precharge gaps. In RAS-only style column strobe stays high and the block drives its own row counter. That counter advances after every cycle and wraps to zero.

The block asks for the bus with a request line and drives no strobe until the grant has been seen. It keeps the request up until the burst is over.

States:
- `S_PAUSE`: the start-up wait.
- `S_IDLE`: nothing is owed.
- `S_WAIT_GNT`: the request is up and the block waits for the grant.
- `S_CAS_LEAD`: column strobe is low ahead of row strobe.
- `S_RAS_ACT`: row strobe is low.
- `S_PRECHG`: row strobe is high again.

Transitions:
- `S_PAUSE` goes to `S_WAIT_GNT` when the pause count ends.
- `S_IDLE` goes to `S_WAIT_GNT` when the backlog is non-zero.
- `S_WAIT_GNT` goes to `S_CAS_LEAD` on a grant in CAS-before-RAS mode.
- `S_WAIT_GNT` goes to `S_RAS_ACT` on a grant in RAS-only mode.
- `S_CAS_LEAD` goes to `S_RAS_ACT` after `T_CSR` cycles.
- `S_RAS_ACT` goes to `S_PRECHG` after `T_RAS` cycles.
- `S_PRECHG` goes to `S_RAS_ACT` when more cycles are owed.
- `S_PRECHG` goes to `S_IDLE` when no more cycles are owed.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and just after it, ras_n=1, cas_n=1, ref_req=0, init_done=0 and ref_row=0.
- R2: ref_req stays 0 for PAUSE_CYCLES clocks after reset is released and becomes 1 on the next clock.
- R3: The first grant starts exactly INIT_CYCLES (8) refresh cycles back to back. init_done rises one clock after the last precharge ends and then stays 1.
- R4: ras_n and cas_n go low only while ref_req is 1, and only after ref_ref_gnt has been seen high in `S_WAIT_GNT`. ref_req drops when the burst ends.
- R5: In CAS-before-RAS style, cas_n goes low T_CSR clocks before ras_n falls and stays low for the T_RAS clocks that ras_n is low.
- R6: Between back-to-back CAS-before-RAS cycles of one burst, cas_n stays low through the precharge. It is high in the precharge of the last cycle.
- R7: In RAS-only style, cas_n stays 1 and ref_row holds steady while ras_n is low. ref_row then advances by one and wraps from all-ones to 0. CAS-before-RAS cycles leave ref_row unchanged.
- R8: After init_done rises, one refresh demand arises every INTERVAL clocks. With the grant held high, successive RAS-only cycles start exactly INTERVAL clocks apart.
- R9: Unserved demands are counted up to MAX_PENDING, and further demands are dropped. One grant then issues the whole count as a single burst.
- R10: ras_only_mode is sampled when the grant is taken: 1 selects RAS-only, 0 selects CAS-before-RAS. Changing it during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_only_mode | input | 1 | 1 = RAS-only style, 0 = CAS-before-RAS style |
| ref_gnt | input | 1 | Grant from the access controller |
| ref_req | output | 1 | Refresh request to the access controller |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ref_row | output | ROW_BITS | Row address for RAS-only refresh |
| init_done | output | 1 | Start-up sequence complete |

## Verification
A wrong state register or a wrong cycle counter shows up within one strobe period as a strobe edge in the wrong clock. The bench compares these against an expected timeline from reset through the end of start-up. A miscounted backlog shows up as the wrong number of row-strobe pulses in a burst, or as a request that stays up after the burst. A faulty row counter shows up at the next row-strobe fall as a wrong address, and the wrap shows up after one full sweep of rows.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        S_PAUSE,
        S_IDLE,
        S_WAIT_GNT,
        S_CAS_LEAD,
        S_RAS_ACT,
        S_PRECHG
    } rfsh_state_t;

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int INTERVAL = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (en)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // R8: demands are spaced, never on two adjacent clocks
    a_r8_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
    parameter int MAX_PENDING = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    output logic pending,
    output logic more
);
    localparam int CW = $clog2(MAX_PENDING + 1);
    localparam logic [CW-1:0] CAP = CW'(MAX_PENDING);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] base;

    always_comb begin
        base = (take && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
        cnt_d = (tick && base != CAP) ? base + 1'b1 : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign pending = (cnt_q != '0);
    assign more    = (cnt_q > CW'(1)) || tick;

    // R9: count never exceeds the configured ceiling
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);

endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
    parameter int ROW_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc,
    output logic [ROW_BITS-1:0] row
);
    logic [ROW_BITS-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            row_q <= '0;
        else if (inc)
            row_q <= row_q + 1'b1;
    end

    assign row = row_q;

    // R7: the top row is followed by row zero
    a_r7_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc) && $past(row_q) == '1) |-> row_q == '0);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int PAUSE_CYCLES = 25000,
    parameter int INIT_CYCLES  = 8,
    parameter int INTERVAL     = 1953,
    parameter int MAX_PENDING  = 4,
    parameter int ROW_BITS     = 12,
    parameter int T_CSR        = 2,
    parameter int T_RAS        = 6,
    parameter int T_RP         = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_only_mode,
    input  logic                ref_gnt,
    output logic                ref_req,
    output logic                ras_n,
    output logic                cas_n,
    output logic [ROW_BITS-1:0] ref_row,
    output logic                init_done
);
    localparam int TW = $clog2(PAUSE_CYCLES + T_CSR + T_RAS + T_RP + 1);
    localparam int IW = $clog2(INIT_CYCLES + 1);
    localparam logic [TW-1:0] LAST_PAUSE = TW'(PAUSE_CYCLES - 1);
    localparam logic [TW-1:0] LAST_CSR   = TW'(T_CSR - 1);
    localparam logic [TW-1:0] LAST_RAS   = TW'(T_RAS - 1);
    localparam logic [TW-1:0] LAST_RP    = TW'(T_RP - 1);

    rfsh_state_t   state_q, state_d;
    logic [TW-1:0] tcnt_q, tcnt_d;
    logic [IW-1:0] init_left_q, init_left_d;
    logic          cbr_q, cbr_d;
    logic          more_q, more_d;
    logic          done_q, done_d;
    logic          last;
    logic          tick, take, bl_pending, bl_more, row_inc;

    rfsh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(done_q), .tick(tick)
    );

    rfsh_backlog #(.MAX_PENDING(MAX_PENDING)) u_backlog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .take(take),
        .pending(bl_pending), .more(bl_more)
    );

    rfsh_row_counter #(.ROW_BITS(ROW_BITS)) u_rows (
        .clk(clk), .rst_n(rst_n), .inc(row_inc), .row(ref_row)
    );

    // end of the current timed state
    always_comb begin
        unique case (state_q)
            S_PAUSE:    last = (tcnt_q == LAST_PAUSE);
            S_CAS_LEAD: last = (tcnt_q == LAST_CSR);
            S_RAS_ACT:  last = (tcnt_q == LAST_RAS);
            S_PRECHG:   last = (tcnt_q == LAST_RP);
            default:    last = 1'b1;
        endcase
    end

    // next-state and counter logic
    always_comb begin
        state_d     = state_q;
        tcnt_d      = last ? '0 : tcnt_q + 1'b1;
        init_left_d = init_left_q;
        cbr_d       = cbr_q;
        more_d      = more_q;
        done_d      = done_q;
        take        = 1'b0;
        row_inc     = 1'b0;
        unique case (state_q)
            S_PAUSE: begin
                if (last) state_d = S_WAIT_GNT;
            end
            S_IDLE: begin
                tcnt_d = '0;
                if (bl_pending) state_d = S_WAIT_GNT;
            end
            S_WAIT_GNT: begin
                tcnt_d = '0;
                if (ref_gnt) begin
                    cbr_d   = !ras_only_mode;
                    state_d = ras_only_mode ? S_RAS_ACT : S_CAS_LEAD;
                end
            end
            S_CAS_LEAD: begin
                if (last) state_d = S_RAS_ACT;
            end
            S_RAS_ACT: begin
                if (last) begin
                    state_d = S_PRECHG;
                    row_inc = !cbr_q;
                    if (done_q) begin
                        take   = 1'b1;
                        more_d = bl_more;
                    end else begin
                        init_left_d = init_left_q - 1'b1;
                        more_d      = (init_left_q > IW'(1));
                    end
                end
            end
            S_PRECHG: begin
                if (last) begin
                    if (more_q) begin
                        state_d = S_RAS_ACT;
                    end else begin
                        state_d = S_IDLE;
                        done_d  = 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_PAUSE;
            tcnt_q      <= '0;
            init_left_q <= IW'(INIT_CYCLES);
            cbr_q       <= 1'b0;
            more_q      <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            state_q     <= state_d;
            tcnt_q      <= tcnt_d;
            init_left_q <= init_left_d;
            cbr_q       <= cbr_d;
            more_q      <= more_d;
            done_q      <= done_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        ref_req   = 1'b0;
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        init_done = done_q;
        unique case (state_q)
            S_WAIT_GNT: ref_req = 1'b1;
            S_CAS_LEAD: begin
                ref_req = 1'b1;
                cas_n   = !cbr_q;
            end
            S_RAS_ACT: begin
                ref_req = 1'b1;
                ras_n   = 1'b0;
                cas_n   = !cbr_q;
            end
            S_PRECHG: begin
                ref_req = 1'b1;
                cas_n   = !(cbr_q && more_q);
            end
            default: ;
        endcase
    end

    // R4: no strobe activity outside a granted request
    a_r4_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> ref_req);

    // R5: when column strobe is low at a row-strobe fall, it was already low
    a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

    // R7: row address holds while the row strobe is low
    a_r7_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n)) |-> $stable(ref_row));

    // R3: ready flag never falls once raised
    a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

endmodule

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;
    localparam int ROWS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0;
    logic gnt = 1'b0;
    logic req, ras_n, cas_n, done;
    logic [ROWS-1:0] row;
    int ecnt = 0;
    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) ecnt <= 0; else ecnt <= ecnt + 1;

    dram_refresh_seq #(
        .PAUSE_CYCLES(20), .INIT_CYCLES(8), .INTERVAL(40), .MAX_PENDING(3),
        .ROW_BITS(ROWS), .T_CSR(2), .T_RAS(4), .T_RP(3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ras_only_mode(mode), .ref_gnt(gnt),
        .ref_req(req), .ras_n(ras_n), .cas_n(cas_n), .ref_row(row),
        .init_done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // {cycle, req, ras_n, cas_n, init_done}; CAS-before-RAS, grant held high
    localparam logic [19:0] VEC [16] = '{
        {16'd0,   4'b0110}, {16'd19,  4'b0110}, {16'd20,  4'b1110},
        {16'd21,  4'b1100}, {16'd22,  4'b1100}, {16'd23,  4'b1000},
        {16'd26,  4'b1000}, {16'd27,  4'b1100}, {16'd29,  4'b1100},
        {16'd30,  4'b1000}, {16'd75,  4'b1000}, {16'd76,  4'b1110},
        {16'd78,  4'b1110}, {16'd79,  4'b0111}, {16'd119, 4'b0111},
        {16'd120, 4'b1111}
    };

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int exp_row;
        int falls;
        int last_fall;
        int cas_rises;
        logic pr, pc;

        // ---- vector table: reset, pause, init sequence, first demand ----
        mode = 1'b0; gnt = 1'b1;
        do_reset();
        check(row == '0, "R1 row at reset", int'(row), 0);
        for (int i = 0; i < 16; i++) begin
            while (ecnt != int'(VEC[i][19:4])) @(negedge clk);
            check({req, ras_n, cas_n, done} == VEC[i][3:0],
                  $sformatf("R1/R2/R3/R5/R6/R8 vec cycle %0d", VEC[i][19:4]),
                  int'({req, ras_n, cas_n, done}), int'(VEC[i][3:0]));
        end

        // ---- backlog saturation, grant handshake, mode sampled at grant ----
        do_reset();
        while (!done) @(negedge clk);
        gnt = 1'b0;
        mode = 1'b1;
        while (!req) @(negedge clk);
        for (int k = 0; k < 160; k++) begin
            @(negedge clk);
            if (!ras_n || !cas_n)
                check(1'b0, "R4 strobe without grant", int'({ras_n, cas_n}), 3);
        end
        check(req == 1'b1, "R4 request held while waiting", int'(req), 1);
        mode = 1'b0; gnt = 1'b1;
        @(negedge clk);
        check({ras_n, cas_n} == 2'b10, "R5 cas leads ras", int'({ras_n, cas_n}), 2);
        mode = 1'b1; gnt = 1'b0;
        pr = ras_n; pc = cas_n; falls = 0; cas_rises = 0;
        for (int k = 0; k < 34; k++) begin
            @(negedge clk);
            if (pr && !ras_n) begin
                falls++;
                check(!cas_n, "R10 burst stays CAS-before-RAS", int'(cas_n), 0);
            end
            if (!pc && cas_n) cas_rises++;
            pr = ras_n; pc = cas_n;
        end
        check(falls == 3, "R9 burst length equals saturated backlog", falls, 3);
        check(cas_rises == 1, "R6 cas stays low between burst cycles", cas_rises, 1);
        check(req == 1'b0, "R4 request dropped after burst", int'(req), 0);
        check(row == '0, "R7 CAS-before-RAS leaves row unchanged", int'(row), 0);

        // ---- RAS-only: row sequence, wrap, interval spacing ----
        mode = 1'b1; gnt = 1'b1;
        do_reset();
        exp_row = 0; falls = 0; last_fall = 0; pr = 1'b1;
        while (falls < 17) begin
            @(negedge clk);
            if (!ras_n && cas_n == 1'b0)
                check(1'b0, "R7 cas low in RAS-only", int'(cas_n), 1);
            if (pr && !ras_n) begin
                check(int'(row) == exp_row, $sformatf("R7 row at refresh %0d", falls),
                      int'(row), exp_row);
                if (falls == 16)
                    check(row == '0, "R7 wrap to zero", int'(row), 0);
                if (falls >= 9)
                    check(ecnt - last_fall == 40, "R8 refresh spacing",
                          ecnt - last_fall, 40);
                last_fall = ecnt;
                exp_row = (exp_row + 1) % (1 << ROWS);
                falls++;
            end
            pr = ras_n;
        end
        check(done == 1'b1, "R3 ready stays high", int'(done), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule